// File: doc/BRIEF.md
# Strap-Addressed I2C Target Byte Engine

This block is the byte-level front end of an I2C target that runs on a system clock at least sixteen times faster than the bus clock. It resynchronises the SCL and SDA lines, finds start, repeated-start and stop conditions, shifts in the address byte MSB first, and compares the upper seven bits with the block's own 7-bit address. The data line is modelled as an output enable: when `sda_oe_o` is high the target pulls SDA low, and when it is low the line is released.

The own address comes from a four-entry table indexed by two strap pins. The straps are captured once, shortly after reset is released, and later changes on them are ignored. The register logic behind the block sees single-cycle strobes: one when a write data byte has arrived and one when the next read byte is needed. It also sees pulses for start and stop and level flags for "addressed" and "read direction".

Top module: `i2c_strap_target`

## Requirements
- R1: The own address follows `strap_i` = {hi, lo}: 2'b00 selects 7'h18, 2'b01 selects 7'h4C, 2'b10 selects 7'h1A and 2'b11 selects 7'h4E. Only that address is acknowledged.
- R2: The straps are captured once after reset. A later change on `strap_i` does not alter which address is acknowledged.
- R3: SDA falling while SCL is high gives a one-cycle `start_o` pulse. SDA rising while SCL is high gives a one-cycle `stop_o` pulse, which also clears `addressed_o` and releases SDA.
- R4: When the first byte after a start carries the own address, the target pulls SDA low for the ninth SCL pulse and raises `addressed_o`. `rd_o` then holds bit 0 of that byte, where 1 means read.
- R5: An address that does not match gets no acknowledge. The target ignores all bus traffic after it, producing no acknowledge and no strobe, until the next start.
- R6: In a write, every data byte (bits taken MSB first on SCL rising) is acknowledged and reported once on `rx_data_o` with a one-cycle `rx_valid_o`. Any number of bytes may follow one address.
- R7: In a read, `tx_req_o` pulses once per byte, and `tx_data_i` is captured at the clock edge that raises it. The byte is then driven MSB first, and each bit changes after an SCL falling edge.
- R8: After a read byte, an acknowledge (SDA low) from the controller on the ninth clock requests the next byte. A no-acknowledge ends the transfer: SDA is released and `addressed_o` drops.
- R9: A start seen while a transfer is in progress, without a stop in between, is accepted. It drops the current selection and restarts address reception.
- R10: SDA is released after the falling SCL edge that ends every acknowledge clock the target drives.
- R11: Out of reset, `sda_oe_o`, `addressed_o`, `rd_o` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 2 | Address select straps {hi, lo} |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| addressed_o | output | 1 | Target currently selected |
| rd_o | output | 1 | Selected transfer is a read |
| start_o | output | 1 | Start or repeated start seen (pulse) |
| stop_o | output | 1 | Stop seen (pulse) |
| rx_valid_o | output | 1 | Write data byte received (pulse) |
| rx_data_o | output | 8 | Received byte |
| tx_req_o | output | 1 | Next read byte wanted (pulse) |
| tx_data_i | input | 8 | Read byte, captured with tx_req_o |

## Verification
The bench builds the block with its default two-stage synchronisers and the default address table. It runs the bus at one SCL period per 40 system clocks, well above the 16x minimum, so every line change crosses the synchroniser long before the controller samples it. It resets the block once with each strap value, which brings all four table entries and their rejection of the neighbouring entry within reach. It also covers strap changes after reset, multi-byte writes and reads, a read ended by a no-acknowledge, and repeated starts to both matching and foreign addresses.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 7;
  localparam int CNT_W   = $clog2(BYTE_W + 1);
  localparam int TABLE_N = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK
  } tgt_state_e;

  // pick one 7-bit entry from a packed table, entry 0 in the low bits
  function automatic logic [ADDR_W-1:0] addr_pick(
    input logic [TABLE_N*ADDR_W-1:0] tbl,
    input logic [1:0]                idx
  );
    return tbl[ADDR_W*int'(idx) +: ADDR_W];
  endfunction

endpackage

// File: rtl/i2c_tgt_linesync.sv
module i2c_tgt_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_q;
  logic              sda_q;
  logic              scl_s;
  logic              sda_s;

  // synchroniser chains, idle-high lines reset to 1
  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff[0] <= 1'b1;
          sda_ff[0] <= 1'b1;
        end else begin
          scl_ff[0] <= scl_i;
          sda_ff[0] <= sda_i;
        end
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else begin
          scl_ff[g] <= scl_ff[g-1];
          sda_ff[g] <= sda_ff[g-1];
        end
      end
    end
  end

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  // previous synchronised sample for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign sda_s_o    = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_tgt_strap.sv
module i2c_tgt_strap
  import i2c_tgt_pkg::*;
#(
  parameter logic [TABLE_N*ADDR_W-1:0] ADDR_TABLE = {7'h4E, 7'h1A, 7'h4C, 7'h18}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        strap_i,
  output logic              done_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic              done_q;
  logic [ADDR_W-1:0] addr_q;
  logic              cap_en;

  // capture exactly once, on the first cycle out of reset
  assign cap_en = ~done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      addr_q <= '0;
    end else if (cap_en) begin
      done_q <= 1'b1;
      addr_q <= addr_pick(ADDR_TABLE, strap_i);
    end
  end

  assign done_o = done_q;
  assign addr_o = addr_q;

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              addr_ok,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              sda_oe_o,
  output logic              sel_o,
  output logic              rd_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              tx_req_o
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  tgt_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] rsh_q, rsh_d;
  logic [BYTE_W-1:0] tsh_q, tsh_d;
  logic [BYTE_W-1:0] rxd_q, rxd_d;
  logic oe_q, oe_d, sel_q, sel_d, rd_q, rd_d, mack_q, mack_d;
  logic rxv_q, rxv_d, txr_q, txr_d, sta_q, sta_d, sto_q, sto_d;
  logic byte_done;

  assign byte_done = scl_fall & (cnt_q == LAST_BIT);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    rsh_d  = rsh_q;
    tsh_d  = tsh_q;
    rxd_d  = rxd_q;
    oe_d   = oe_q;
    sel_d  = sel_q;
    rd_d   = rd_q;
    mack_d = mack_q;
    rxv_d  = 1'b0;
    txr_d  = 1'b0;
    sta_d  = 1'b0;
    sto_d  = 1'b0;
    if (start_det) begin
      st_d  = ST_ADDR;
      cnt_d = '0;
      oe_d  = 1'b0;
      sel_d = 1'b0;
      rd_d  = 1'b0;
      sta_d = 1'b1;
    end else if (stop_det) begin
      st_d  = ST_IDLE;
      oe_d  = 1'b0;
      sel_d = 1'b0;
      rd_d  = 1'b0;
      sto_d = 1'b1;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_WDAT: begin
          if (scl_rise) begin
            rsh_d = {rsh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (byte_done) begin
            if (st_q == ST_WDAT) begin
              rxv_d = 1'b1;
              rxd_d = rsh_q;
              oe_d  = 1'b1;
              st_d  = ST_WACK;
            end else if (addr_ok && rsh_q[BYTE_W-1:1] == own_addr) begin
              oe_d  = 1'b1;
              sel_d = 1'b1;
              rd_d  = rsh_q[0];
              st_d  = ST_AACK;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rd_q) begin
              txr_d = 1'b1;
              oe_d  = ~tx_data_i[BYTE_W-1];
              tsh_d = {tx_data_i[BYTE_W-2:0], 1'b0};
              st_d  = ST_RDAT;
            end else begin
              oe_d = 1'b0;
              st_d = ST_WDAT;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            oe_d  = 1'b0;
            cnt_d = '0;
            st_d  = ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (byte_done) begin
            oe_d = 1'b0;
            st_d = ST_RACK;
          end else if (scl_fall) begin
            oe_d  = ~tsh_q[BYTE_W-1];
            tsh_d = {tsh_q[BYTE_W-2:0], 1'b0};
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              txr_d = 1'b1;
              cnt_d = '0;
              oe_d  = ~tx_data_i[BYTE_W-1];
              tsh_d = {tx_data_i[BYTE_W-2:0], 1'b0};
              st_d  = ST_RDAT;
            end else begin
              st_d  = ST_IDLE;
              sel_d = 1'b0;
              rd_d  = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      rsh_q  <= '0;
      tsh_q  <= '0;
      rxd_q  <= '0;
      oe_q   <= 1'b0;
      sel_q  <= 1'b0;
      rd_q   <= 1'b0;
      mack_q <= 1'b0;
      rxv_q  <= 1'b0;
      txr_q  <= 1'b0;
      sta_q  <= 1'b0;
      sto_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      rsh_q  <= rsh_d;
      tsh_q  <= tsh_d;
      rxd_q  <= rxd_d;
      oe_q   <= oe_d;
      sel_q  <= sel_d;
      rd_q   <= rd_d;
      mack_q <= mack_d;
      rxv_q  <= rxv_d;
      txr_q  <= txr_d;
      sta_q  <= sta_d;
      sto_q  <= sto_d;
    end
  end

  assign sda_oe_o   = oe_q;
  assign sel_o      = sel_q;
  assign rd_o       = rd_q;
  assign start_o    = sta_q;
  assign stop_o     = sto_q;
  assign rx_valid_o = rxv_q;
  assign rx_data_o  = rxd_q;
  assign tx_req_o   = txr_q;

endmodule

// File: rtl/i2c_strap_target.sv
module i2c_strap_target
  import i2c_tgt_pkg::*;
#(
  parameter int                        SYNC_STAGES = 2,
  parameter logic [TABLE_N*ADDR_W-1:0] ADDR_TABLE  = {7'h4E, 7'h1A, 7'h4C, 7'h18}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  strap_i,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  output logic        addressed_o,
  output logic        rd_o,
  output logic        start_o,
  output logic        stop_o,
  output logic        rx_valid_o,
  output logic [7:0]  rx_data_o,
  output logic        tx_req_o,
  input  logic [7:0]  tx_data_i
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              strap_done;
  logic [ADDR_W-1:0] own_addr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  i2c_tgt_linesync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_tgt_strap #(.ADDR_TABLE(ADDR_TABLE)) u_strap (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .strap_i (strap_i),
    .done_o  (strap_done),
    .addr_o  (own_addr)
  );

  i2c_tgt_engine u_eng (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .addr_ok    (strap_done),
    .own_addr   (own_addr),
    .tx_data_i  (tx_data_i),
    .sda_oe_o   (sda_oe_o),
    .sel_o      (addressed_o),
    .rd_o       (rd_o),
    .start_o    (start_o),
    .stop_o     (stop_o),
    .rx_valid_o (rx_valid_o),
    .rx_data_o  (rx_data_o),
    .tx_req_o   (tx_req_o)
  );

endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe_o,
  input logic       addressed_o,
  input logic       rd_o,
  input logic       start_o,
  input logic       stop_o,
  input logic       rx_valid_o,
  input logic       tx_req_o,
  input logic       strap_done,
  input logic [6:0] own_addr
);

  // R4
  oe_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe_o |-> addressed_o);

  // R3
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> (!sda_oe_o && !addressed_o));

  // R9
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (!sda_oe_o && !addressed_o && !rd_o));

  // R6
  rx_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> (addressed_o && !rd_o));

  // R7
  tx_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_o |-> (addressed_o && rd_o));

  // R2
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strap_done |=> (strap_done && $stable(own_addr)));

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_valid_o, tx_req_o, start_o, stop_o}));

endmodule

bind i2c_strap_target i2c_tgt_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sda_oe_o    (sda_oe_o),
  .addressed_o (addressed_o),
  .rd_o        (rd_o),
  .start_o     (start_o),
  .stop_o      (stop_o),
  .rx_valid_o  (rx_valid_o),
  .tx_req_o    (tx_req_o),
  .strap_done  (strap_done),
  .own_addr    (own_addr)
);

// File: tb/sim_i2c_strap_target.sv
module sim_i2c_strap_target;

  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 10;  // system clocks per quarter SCL period

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] strap = 2'b00;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_line;
  logic [7:0] tx_data = 8'h00;
  logic       sda_oe, addressed, rd, start_p, stop_p, rx_valid, tx_req;
  logic [7:0] rx_data;

  int checks = 0;
  int errors = 0;
  int n_start = 0;
  int n_stop = 0;
  logic [7:0] exp_q[$];

  localparam logic [6:0] EXP_ADDR [4] = '{7'h18, 7'h4C, 7'h1A, 7'h4E};

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_strap_target u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .strap_i     (strap),
    .scl_i       (scl),
    .sda_i       (sda_line),
    .sda_oe_o    (sda_oe),
    .addressed_o (addressed),
    .rd_o        (rd),
    .start_o     (start_p),
    .stop_o      (stop_p),
    .rx_valid_o  (rx_valid),
    .rx_data_o   (rx_data),
    .tx_req_o    (tx_req),
    .tx_data_i   (tx_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard for write bytes, strobe counts, read data source
  always @(negedge clk) begin
    if (rx_valid) begin
      if (exp_q.size() == 0) check(0, "R5 unexpected rx byte", int'(rx_data), 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        check(rx_data == e, "R6 rx byte", int'(rx_data), int'(e));
      end
    end
    if (start_p) n_start++;
    if (stop_p)  n_stop++;
    if (tx_req)  tx_data <= tx_data + 8'h3B;
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] s);
    rst_n = 1'b0;
    strap = s;
    wclk(4);
    rst_n = 1'b1;
    wclk(6);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wclk(QTR);
    scl = 1'b1;   wclk(QTR);
    sda_m = 1'b0; wclk(QTR);
    scl = 1'b0;   wclk(QTR);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(QTR);
    scl = 1'b1;   wclk(QTR);
    sda_m = 1'b1; wclk(2*QTR);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b;  wclk(QTR);
    scl = 1'b1; wclk(2*QTR);
    scl = 1'b0; wclk(QTR);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wclk(QTR);
    scl = 1'b1;   wclk(QTR);
    b = sda_line; wclk(QTR);
    scl = 1'b0;   wclk(QTR);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(output logic [7:0] d, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~give_ack);
  endtask

  initial begin
    logic       ack;
    logic [7:0] d;
    logic [7:0] e;
    int         s0, p0;

    // R11 reset state
    do_reset(2'b00);
    check(sda_oe == 0 && addressed == 0 && rd == 0, "R11 reset outputs",
          {sda_oe, addressed, rd}, 0);
    check(rx_valid == 0 && tx_req == 0 && start_p == 0 && stop_p == 0,
          "R11 reset strobes", {rx_valid, tx_req, start_p, stop_p}, 0);

    // R1 each strap value: own address acked, neighbour entry not
    for (int s = 0; s < 4; s++) begin
      do_reset(2'(s));
      bus_start();
      put_byte({EXP_ADDR[s], 1'b0}, ack);
      check(ack == 1, "R1 own address ack", ack, 1);
      check(sda_oe == 0, "R10 release after address ack", sda_oe, 0);
      exp_q.push_back(8'h30 + 8'(s));
      put_byte(8'h30 + 8'(s), ack);
      check(ack == 1, "R6 data ack", ack, 1);
      bus_stop();
      check(addressed == 0 && sda_oe == 0, "R3 stop clears", {addressed, sda_oe}, 0);
      bus_start();
      put_byte({EXP_ADDR[(s+1)%4], 1'b0}, ack);
      check(ack == 0, "R1 foreign address no ack", ack, 0);
      bus_stop();
    end

    // R2 strap change after reset is ignored
    do_reset(2'b00);
    strap = 2'b11;
    wclk(5);
    bus_start();
    put_byte({7'h4E, 1'b0}, ack);
    check(ack == 0, "R2 new strap address ignored", ack, 0);
    bus_stop();
    bus_start();
    put_byte({7'h18, 1'b0}, ack);
    check(ack == 1, "R2 captured address kept", ack, 1);
    bus_stop();

    // R6 multi-byte write, R3 start/stop pulses
    s0 = n_start; p0 = n_stop;
    bus_start();
    put_byte({7'h18, 1'b0}, ack);
    check(ack == 1 && rd == 0, "R4 write select", {ack, rd}, 2);
    foreach (exp_q[i]) ;
    begin
      logic [7:0] pat [3] = '{8'h00, 8'hFF, 8'h5A};
      for (int k = 0; k < 3; k++) begin
        exp_q.push_back(pat[k]);
        put_byte(pat[k], ack);
        check(ack == 1, "R6 multi ack", ack, 1);
        check(sda_oe == 0, "R10 release after data ack", sda_oe, 0);
      end
    end
    bus_stop();
    check(n_start == s0 + 1, "R3 start pulse count", n_start - s0, 1);
    check(n_stop == p0 + 1, "R3 stop pulse count", n_stop - p0, 1);

    // R5 foreign address followed by data: ignored
    bus_start();
    put_byte({7'h4C, 1'b0}, ack);
    check(ack == 0, "R5 no address ack", ack, 0);
    put_byte(8'h00, ack);
    check(ack == 0 && addressed == 0, "R5 data ignored", {ack, addressed}, 0);
    bus_stop();

    // R7 R8 read of three bytes, last one not acknowledged
    tx_data = 8'hA5;
    wclk(2);
    e = tx_data;
    bus_start();
    put_byte({7'h18, 1'b1}, ack);
    check(ack == 1, "R4 read address ack", ack, 1);
    check(rd == 1 && addressed == 1, "R4 read direction flag", {rd, addressed}, 3);
    get_byte(d, 1'b1);
    check(d == e, "R7 first read byte", d, e);
    get_byte(d, 1'b1);
    check(d == 8'(e + 8'h3B), "R8 ack fetches next byte", d, 8'(e + 8'h3B));
    get_byte(d, 1'b0);
    check(d == 8'(e + 8'h76), "R7 third read byte", d, 8'(e + 8'h76));
    check(addressed == 0 && sda_oe == 0, "R8 nack ends transfer", {addressed, sda_oe}, 0);
    bus_stop();

    // R9 repeated start from write into read
    s0 = n_start;
    bus_start();
    put_byte({7'h18, 1'b0}, ack);
    exp_q.push_back(8'hC3);
    put_byte(8'hC3, ack);
    check(ack == 1, "R9 write before restart", ack, 1);
    e = tx_data;
    bus_start();
    put_byte({7'h18, 1'b1}, ack);
    check(ack == 1 && rd == 1, "R9 restart read select", {ack, rd}, 3);
    get_byte(d, 1'b0);
    check(d == e, "R9 read after restart", d, e);
    bus_stop();
    check(n_start == s0 + 2, "R9 two start pulses", n_start - s0, 2);

    // R9 repeated start to a foreign address drops selection
    bus_start();
    put_byte({7'h18, 1'b0}, ack);
    check(addressed == 1, "R9 selected first", addressed, 1);
    bus_start();
    check(addressed == 0, "R9 restart drops selection", addressed, 0);
    put_byte({7'h1A, 1'b0}, ack);
    check(ack == 0 && addressed == 0, "R9 foreign after restart", {ack, addressed}, 0);
    bus_stop();

    wclk(10);
    check(exp_q.size() == 0, "R6 all written bytes seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule